// File: doc/BRIEF.md
# Serial EEPROM Access Sequencer

This block sits between a host register port and a byte-wide EEPROM port. It has four small registers: control/status, EEPROM address, data and destination base. Through them the host runs single-byte reads and writes. It can also start a burst that copies records from the EEPROM into a 24-bit on-chip memory space. Each command bit clears itself when its operation finishes. A status bit shows that work is still pending.

Each EEPROM byte is moved with a request/acknowledge handshake. During a burst the block reads records made of three bytes: a 16-bit offset (low byte first) and one data byte. For each record it issues one memory write strobe. The destination address joins the base register, which gives the top bits, to the low 15 bits of the offset. An offset of 0xFFFF ends the burst. Where a burst starts depends on history. After reset it starts at EEPROM address 0. After any access it starts at the address after the last byte touched.

Top module: `eeprom_seq`

## Requirements
- R1: After reset all four registers read 0, no EEPROM request is raised and no memory strobe is issued.
- R2: Writing the control register with bit 0 set writes the data register's byte to the EEPROM at the address register's location. Bit 0 then clears itself.
- R3: Writing the control register with bit 1 set fetches the byte at the address register's location into the data register. Bit 1 reads 1 until the fetch is done, and the data register is valid once it reads 0.
- R4: When bits 0 and 1 are set in the same control write, the write is performed first and the read second, both at the same address.
- R5: A burst (control bit 2) started after reset, with no access before it, reads from EEPROM address 0.
- R6: A burst started after any earlier access begins at the address one above the last EEPROM byte read or written.
- R7: Each burst record is read as offset low byte, then offset high byte, then data byte. It yields exactly one single-cycle memory strobe. The strobe carries the address {base[8:0], offset[14:0]} (offset bit 15 ignored) and the data byte.
- R8: A record offset of 0xFFFF ends the burst. No data byte is fetched for it, no strobe is issued, and control bit 2 clears.
- R9: Control bit 3 reads 1 while any command bit is set. While it is 1, host writes to every register, new commands included, are ignored.
- R10: A raised EEPROM request keeps its address and direction stable until acknowledged. Each acknowledge completes exactly one byte transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Host register write strobe |
| reg_idx_i | input | 2 | Register select: 0 control, 1 address, 2 data, 3 base |
| reg_wdata_i | input | 16 | Host write data |
| reg_rdata_o | output | 16 | Read data of the selected register |
| ee_req_o | output | 1 | EEPROM byte transfer request |
| ee_we_o | output | 1 | Transfer direction, 1 = write |
| ee_addr_o | output | 16 | EEPROM byte address |
| ee_wdata_o | output | 8 | Byte to write |
| ee_ack_i | input | 1 | Transfer done, one cycle |
| ee_rdata_i | input | 8 | Byte read, valid with ee_ack_i |
| mem_we_o | output | 1 | Destination memory write strobe |
| mem_addr_o | output | 24 | Destination address |
| mem_data_o | output | 8 | Destination data |

## Verification
The bench builds the block with its default parameters: a 16-bit EEPROM address, 8-bit bytes and a 9-bit base that forms a 24-bit destination. With those values the bench can reach the case where offset bit 15 is dropped from the destination address, as well as the all-ones terminator. The EEPROM model decodes 256 bytes and acknowledges after a random latency of 0 to 2 cycles, so the stable-request rule is exercised across varying waits. Bursts are run straight after reset, straight after a previous burst, and after single accesses, which covers every source of the start address.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;
  localparam int CMD_W     = 3;
  localparam int CMD_WR    = 0;
  localparam int CMD_RD    = 1;
  localparam int CMD_BURST = 2;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_ADDR = 2'd1;
  localparam logic [1:0] REG_DATA = 2'd2;
  localparam logic [1:0] REG_BASE = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SWR, ST_SRD, ST_BLO, ST_BHI, ST_BDAT
  } seq_state_e;
endpackage

// File: rtl/eeprom_seq_regs.sv
module eeprom_seq_regs
  import eeprom_seq_pkg::*;
#(
  parameter int EE_AW  = 16,
  parameter int DW     = 8,
  parameter int BASE_W = 9,
  parameter int REG_DW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_idx_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  output logic [REG_DW-1:0] reg_rdata_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic [EE_AW-1:0]  addr_o,
  output logic [DW-1:0]     data_o,
  output logic [BASE_W-1:0] base_o,
  input  logic [CMD_W-1:0]  clr_i,
  input  logic              load_i,
  input  logic [DW-1:0]     load_data_i
);
  logic [CMD_W-1:0]  cmd_q;
  logic [EE_AW-1:0]  addr_q;
  logic [DW-1:0]     data_q;
  logic [BASE_W-1:0] base_q;
  logic              busy;

  assign busy = |cmd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
      base_q <= '0;
    end else begin
      cmd_q <= cmd_q & ~clr_i;
      if (load_i) data_q <= load_data_i;
      // all host writes are dropped while any command is pending
      if (reg_we_i && !busy) begin
        unique case (reg_idx_i)
          REG_CTRL: cmd_q  <= reg_wdata_i[CMD_W-1:0];
          REG_ADDR: addr_q <= reg_wdata_i[EE_AW-1:0];
          REG_DATA: data_q <= reg_wdata_i[DW-1:0];
          default:  base_q <= reg_wdata_i[BASE_W-1:0];
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_idx_i)
      REG_CTRL: reg_rdata_o[CMD_W:0]    = {busy, cmd_q};
      REG_ADDR: reg_rdata_o[EE_AW-1:0]  = addr_q;
      REG_DATA: reg_rdata_o[DW-1:0]     = data_q;
      default:  reg_rdata_o[BASE_W-1:0] = base_q;
    endcase
  end

  assign cmd_o  = cmd_q;
  assign addr_o = addr_q;
  assign data_o = data_q;
  assign base_o = base_q;
endmodule

// File: rtl/eeprom_seq_ctrl.sv
module eeprom_seq_ctrl
  import eeprom_seq_pkg::*;
#(
  parameter int EE_AW  = 16,
  parameter int DW     = 8,
  parameter int BASE_W = 9,
  parameter int MEM_AW = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [EE_AW-1:0]  addr_i,
  input  logic [DW-1:0]     data_i,
  input  logic [BASE_W-1:0] base_i,
  output logic [CMD_W-1:0]  clr_o,
  output logic              load_o,
  output logic [DW-1:0]     load_data_o,
  output logic              ee_req_o,
  output logic              ee_we_o,
  output logic [EE_AW-1:0]  ee_addr_o,
  output logic [DW-1:0]     ee_wdata_o,
  input  logic              ee_ack_i,
  input  logic [DW-1:0]     ee_rdata_i,
  output logic              mem_we_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic [DW-1:0]     mem_data_o
);
  localparam int OFF_W = MEM_AW - BASE_W;

  seq_state_e        state_q, state_d;
  logic [EE_AW-1:0]  ptr_q;
  logic [DW-1:0]     lo_q;
  logic [2*DW-1:0]   off_q;
  logic              xfer;
  logic              single;

  assign single      = (state_q == ST_SWR) || (state_q == ST_SRD);
  assign ee_req_o    = (state_q != ST_IDLE);
  assign ee_we_o     = (state_q == ST_SWR);
  assign ee_addr_o   = single ? addr_i : ptr_q;
  assign ee_wdata_o  = data_i;
  assign xfer        = ee_req_o && ee_ack_i;
  assign load_data_o = ee_rdata_i;

  always_comb begin
    state_d = state_q;
    clr_o   = '0;
    load_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        // service order: write, read, burst
        if (cmd_i[CMD_WR])         state_d = ST_SWR;
        else if (cmd_i[CMD_RD])    state_d = ST_SRD;
        else if (cmd_i[CMD_BURST]) state_d = ST_BLO;
      end
      ST_SWR: if (xfer) begin
        clr_o[CMD_WR] = 1'b1;
        state_d       = ST_IDLE;
      end
      ST_SRD: if (xfer) begin
        clr_o[CMD_RD] = 1'b1;
        load_o        = 1'b1;
        state_d       = ST_IDLE;
      end
      ST_BLO: if (xfer) state_d = ST_BHI;
      ST_BHI: if (xfer) begin
        if ({ee_rdata_i, lo_q} == '1) begin
          clr_o[CMD_BURST] = 1'b1;
          state_d          = ST_IDLE;
        end else begin
          state_d = ST_BDAT;
        end
      end
      ST_BDAT: if (xfer) state_d = ST_BLO;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      ptr_q      <= '0;
      lo_q       <= '0;
      off_q      <= '0;
      mem_we_o   <= 1'b0;
      mem_addr_o <= '0;
      mem_data_o <= '0;
    end else begin
      state_q  <= state_d;
      mem_we_o <= 1'b0;
      // pointer reset to 0 doubles as the "no access yet" start point
      if (xfer) ptr_q <= ee_addr_o + EE_AW'(1);
      if (xfer && state_q == ST_BLO) lo_q  <= ee_rdata_i;
      if (xfer && state_q == ST_BHI) off_q <= {ee_rdata_i, lo_q};
      if (xfer && state_q == ST_BDAT) begin
        mem_we_o   <= 1'b1;
        mem_addr_o <= {base_i, off_q[OFF_W-1:0]};
        mem_data_o <= ee_rdata_i;
      end
    end
  end
endmodule

// File: rtl/eeprom_seq.sv
module eeprom_seq
  import eeprom_seq_pkg::*;
#(
  parameter int EE_AW  = 16,
  parameter int DW     = 8,
  parameter int BASE_W = 9,
  parameter int MEM_AW = 24,
  parameter int REG_DW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_idx_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  output logic [REG_DW-1:0] reg_rdata_o,
  output logic              ee_req_o,
  output logic              ee_we_o,
  output logic [EE_AW-1:0]  ee_addr_o,
  output logic [DW-1:0]     ee_wdata_o,
  input  logic              ee_ack_i,
  input  logic [DW-1:0]     ee_rdata_i,
  output logic              mem_we_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic [DW-1:0]     mem_data_o
);
  logic [CMD_W-1:0]  cmd_w;
  logic [CMD_W-1:0]  clr_w;
  logic [EE_AW-1:0]  addr_w;
  logic [DW-1:0]     data_w;
  logic [BASE_W-1:0] base_w;
  logic              load_w;
  logic [DW-1:0]     load_data_w;

  eeprom_seq_regs #(
    .EE_AW(EE_AW), .DW(DW), .BASE_W(BASE_W), .REG_DW(REG_DW)
  ) u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_idx_i, .reg_wdata_i, .reg_rdata_o,
    .cmd_o(cmd_w), .addr_o(addr_w), .data_o(data_w), .base_o(base_w),
    .clr_i(clr_w), .load_i(load_w), .load_data_i(load_data_w)
  );

  eeprom_seq_ctrl #(
    .EE_AW(EE_AW), .DW(DW), .BASE_W(BASE_W), .MEM_AW(MEM_AW)
  ) u_ctrl (
    .clk_i, .rst_ni,
    .cmd_i(cmd_w), .addr_i(addr_w), .data_i(data_w), .base_i(base_w),
    .clr_o(clr_w), .load_o(load_w), .load_data_o(load_data_w),
    .ee_req_o, .ee_we_o, .ee_addr_o, .ee_wdata_o, .ee_ack_i, .ee_rdata_i,
    .mem_we_o, .mem_addr_o, .mem_data_o
  );
endmodule

// File: rtl/eeprom_seq_chk.sv
module eeprom_seq_chk
  import eeprom_seq_pkg::*;
#(
  parameter int EE_AW = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic [1:0]       reg_idx_i,
  input logic [CMD_W-1:0] cmd,
  input logic             ee_req_o,
  input logic             ee_we_o,
  input logic [EE_AW-1:0] ee_addr_o,
  input logic             ee_ack_i,
  input logic             mem_we_o
);
  assert_req_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ee_req_o && !ee_ack_i |=> ee_req_o && $stable(ee_addr_o) && $stable(ee_we_o));

  assert_we_in_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ee_we_o |-> ee_req_o);

  assert_write_first_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ee_req_o && cmd[CMD_WR] |-> ee_we_o);

  assert_busy_ignore_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cmd) && reg_we_i && reg_idx_i == REG_CTRL |=> (cmd & ~$past(cmd)) == '0);

  assert_mem_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);

  assert_mem_in_burst_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> cmd[CMD_BURST]);
endmodule

bind eeprom_seq eeprom_seq_chk #(.EE_AW(EE_AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_idx_i(reg_idx_i),
  .cmd(cmd_w), .ee_req_o(ee_req_o), .ee_we_o(ee_we_o), .ee_addr_o(ee_addr_o),
  .ee_ack_i(ee_ack_i), .mem_we_o(mem_we_o)
);

// File: tb/eeprom_seq_test.sv
module eeprom_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_idx = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        ee_req, ee_we, ee_ack = 1'b0;
  logic [15:0] ee_addr;
  logic [7:0]  ee_wdata, ee_rdata = '0;
  logic        mem_we;
  logic [23:0] mem_addr;
  logic [7:0]  mem_data;

  int n_chk = 0;
  int n_bad = 0;

  eeprom_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_idx_i(reg_idx),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .ee_req_o(ee_req), .ee_we_o(ee_we), .ee_addr_o(ee_addr), .ee_wdata_o(ee_wdata),
    .ee_ack_i(ee_ack), .ee_rdata_i(ee_rdata),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_data_o(mem_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // EEPROM model, 256 bytes decoded, random ack latency
  logic [7:0] eemem [256];
  int lat = 0;
  always @(posedge clk) begin
    ee_ack <= 1'b0;
    if (ee_req && !ee_ack) begin
      if (lat == 0) begin
        ee_ack <= 1'b1;
        if (ee_we) eemem[ee_addr[7:0]] <= ee_wdata;
        else       ee_rdata <= eemem[ee_addr[7:0]];
        lat <= int'($urandom % 3);
      end else begin
        lat <= lat - 1;
      end
    end
  end

  logic        log_we   [$];
  logic [15:0] log_addr [$];
  logic [23:0] got_addr [$];
  logic [7:0]  got_data [$];
  always @(posedge clk) begin
    if (ee_req && ee_ack) begin
      log_we.push_back(ee_we);
      log_addr.push_back(ee_addr);
    end
    if (mem_we) begin
      got_addr.push_back(mem_addr);
      got_data.push_back(mem_data);
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] idx, input logic [15:0] val);
    @(negedge clk);
    reg_we = 1'b1; reg_idx = idx; reg_wdata = val;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] idx, output logic [15:0] val);
    @(negedge clk);
    reg_idx = idx;
    #1 val = reg_rdata;
  endtask

  task automatic wait_idle(input string req);
    logic [15:0] v;
    int n = 0;
    do begin
      rd_reg(2'd0, v);
      n++;
    end while (v[3] && n < 3000);
    check(req, {31'd0, v[3]}, 32'd0);
  endtask

  function automatic void clear_logs();
    log_we.delete(); log_addr.delete(); got_addr.delete(); got_data.delete();
  endfunction

  // place nrec records at start, run burst, compare
  task automatic run_burst(input int start, input int nrec, input logic [8:0] base,
                           input string start_req);
    logic [23:0] ea [$];
    logic [7:0]  ed [$];
    logic [15:0] v, addr_before;
    for (int k = 0; k < nrec; k++) begin
      logic [15:0] off = 16'($urandom);
      logic [7:0]  d   = 8'($urandom);
      if (k == 0) off = 16'h8123;
      if (off == 16'hFFFF) off = 16'h7FFF;
      eemem[8'(start + 3*k)]     = off[7:0];
      eemem[8'(start + 3*k + 1)] = off[15:8];
      eemem[8'(start + 3*k + 2)] = d;
      ea.push_back({base, off[14:0]});
      ed.push_back(d);
    end
    eemem[8'(start + 3*nrec)]     = 8'hFF;
    eemem[8'(start + 3*nrec + 1)] = 8'hFF;
    rd_reg(2'd1, addr_before);
    wr_reg(2'd3, {7'd0, base});
    clear_logs();
    wr_reg(2'd0, 16'h0004);
    // R9: these land while busy and must be dropped
    wr_reg(2'd1, addr_before ^ 16'h0055);
    wr_reg(2'd0, 16'h0002);
    wait_idle("R8 burst end");
    check(start_req, {16'd0, log_addr.size() > 0 ? log_addr[0] : 16'hDEAD}, start);
    check("R10 transfer count", log_addr.size(), 3*nrec + 2);
    check("R8 strobe count", got_addr.size(), nrec);
    for (int k = 0; k < nrec && k < got_addr.size(); k++) begin
      check("R7 dest addr", got_addr[k], ea[k]);
      check("R7 dest data", got_data[k], ed[k]);
    end
    rd_reg(2'd1, v);
    check("R9 addr write ignored", v, addr_before);
    rd_reg(2'd0, v);
    check("R8 ctrl cleared", v, 16'h0000);
  endtask

  initial begin
    logic [15:0] v;
    int nxt;
    void'($urandom(32'd4711));
    for (int i = 0; i < 256; i++) eemem[i] = 8'($urandom);
    repeat (3) @(posedge clk);
    #1 check("R1 req at reset", {31'd0, ee_req}, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      rd_reg(2'(i), v);
      check("R1 reg reset", v, 0);
    end
    check("R1 strobe at reset", {31'd0, mem_we}, 0);

    run_burst(0, 3, 9'h1A5, "R5 start after reset");
    nxt = 3*3 + 2;
    run_burst(nxt, 4, 9'h0C3, "R6 start after burst");

    // R2 single write, busy visible
    wr_reg(2'd1, 16'h0040);
    wr_reg(2'd2, 16'h005C);
    clear_logs();
    wr_reg(2'd0, 16'h0001);
    rd_reg(2'd0, v);
    check("R9 busy during write", {28'd0, v[3:0]}, 32'h9);
    wait_idle("R2 done");
    check("R2 eeprom byte", eemem[8'h40], 8'h5C);
    check("R2 one write", log_we.size() == 1 && log_we[0] == 1'b1, 1);

    // R3 single read
    eemem[8'h41] = 8'h3E;
    wr_reg(2'd1, 16'h0041);
    wr_reg(2'd0, 16'h0002);
    rd_reg(2'd0, v);
    check("R3 read bit pending", {30'd0, v[1:0]}, 32'h2);
    wait_idle("R3 done");
    rd_reg(2'd2, v);
    check("R3 data", v, 16'h003E);

    // R4 write then read
    wr_reg(2'd1, 16'h0050);
    wr_reg(2'd2, 16'h00A7);
    clear_logs();
    wr_reg(2'd0, 16'h0003);
    wait_idle("R4 done");
    check("R4 order", {log_we.size() == 2 ? {log_we[0], log_we[1]} : 2'b00}, 2'b10);
    check("R4 eeprom", eemem[8'h50], 8'hA7);
    rd_reg(2'd2, v);
    check("R4 readback", v, 16'h00A7);
    run_burst(16'h51, 3, 9'h001, "R6 start after single");

    // random singles
    for (int it = 0; it < 24; it++) begin
      logic [7:0] a = 8'($urandom % 8'hC0);
      logic [7:0] d = 8'($urandom);
      int op = int'($urandom % 3);
      logic [7:0] pre = eemem[a];
      wr_reg(2'd1, {8'd0, a});
      wr_reg(2'd2, {8'd0, d});
      wr_reg(2'd0, op == 0 ? 16'h1 : op == 1 ? 16'h2 : 16'h3);
      wait_idle("R9 random idle");
      rd_reg(2'd2, v);
      if (op == 0) check("R2 random write", eemem[a], d);
      if (op == 1) check("R3 random read", v, {8'd0, pre});
      if (op == 2) check("R4 random both", v, {8'd0, d});
      nxt = a + 1;
    end
    run_burst(nxt, 4, 9'h1FF, "R6 start after random");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule